// File: doc/BRIEF.md
# Symbolic-Address Load/Store Redundancy Filter

This block sits after the renaming logic of an out-of-order core, where every memory address has already been reduced to a physical base register plus a constant offset. Memory operations arrive one per beat, and the block compares them against a small, fully associative table of symbolic addresses. From that comparison it decides what happens to each operation. A load that repeats an earlier load becomes a register copy. A load that reads a location written by a recent store is forwarded from that store's data register. A store whose data equals the value already recorded for its location is dropped. Any other operation is issued normally.

For each operation the block returns an action code. For a copied or forwarded load it also returns a feedback record. This record names the load's destination register and the register that already holds the value, so the renaming logic can propagate the copy into younger instructions. A separate plain strobe reports a physical register being redefined, and every table entry that depends on that register is dropped. An operation flagged as memory-mapped I/O always passes through unchanged and leaves the table untouched.

Operations enter on a valid/ready stream and results leave on another. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. The table is updated on that edge, and the result appears on the output registers in the following cycle. `in_ready` is high whenever the output register is empty or is being drained that cycle (`out_ready`). A result stays valid and unchanged until it is taken. A sender must keep an operation stable until it is accepted.

Top module: `symaddr_mem_filter`

## Requirements
- R1: The result of an operation accepted on edge k is presented from edge k onward with `out_valid` high. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result holds stable.
- R2: A non-I/O load whose base and offset match no valid entry gets action 0 (issue). It is allocated an entry at the round-robin pointer, with its destination register as the data tag and its data marked unknown.
- R3: A non-I/O load that matches a valid entry written by a load in base, offset and size gets action 1 (copy). The copy source is that entry's data tag.
- R4: A non-I/O load that matches a valid entry written by a store in base, offset and size gets action 2 (forward). The copy source is the store's data register, and the known value travels with it.
- R5: A non-I/O store that matches an entry in base, offset and size gets action 4 (drop) and leaves the table unchanged. This happens when the entry's data tag equals the store's data register, or when both data values are known and equal.
- R6: An operation flagged as I/O gets action 5 (pass) and changes no entry and no pointer.
- R7: Any other non-I/O store gets action 3 (issue). If any valid entry has a different base, all entries are invalidated and the store is allocated at the pointer. Otherwise, same-base entries whose byte range overlaps the store are invalidated, and the store is written in place on an exact match or at the pointer otherwise.
- R8: A register-redefinition strobe invalidates every entry whose base or data tag equals the named register. This takes effect after any same-cycle operation update.
- R9: A load whose base and offset match an entry of a different size gets action 0 and overwrites that entry in place, without advancing the pointer.
- R10: The feedback record is valid only for actions 1 and 2. It carries the load's destination, the source tag, and the entry's known flag and value; all of its fields are zero otherwise.
- R11: Allocation uses a pointer that steps by one, wrapping at the table depth, on each allocation that is not in place. The oldest allocation is the next victim.
- R12: After reset, the table is empty, the pointer is zero, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_is_store | input | 1 | 1 for store, 0 for load |
| in_is_io | input | 1 | Access is memory-mapped I/O |
| in_base | input | PREG_W | Physical base register of the address |
| in_off | input | OFF_W | Constant offset of the address |
| in_size | input | 2 | Access size, 2^n bytes |
| in_tag | input | PREG_W | Load destination or store data register |
| in_known | input | 1 | Store data value is known |
| in_value | input | DATA_W | Known store data value |
| redef_valid | input | 1 | A physical register is being redefined |
| redef_tag | input | PREG_W | Redefined register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_act | output | 3 | Action code (0..5 as in the requirements) |
| out_fb_valid | output | 1 | Feedback record valid |
| out_fb_dst | output | PREG_W | Register receiving the copy |
| out_fb_src | output | PREG_W | Register already holding the value |
| out_fb_known | output | 1 | Value is known |
| out_fb_value | output | DATA_W | Known value |

## Verification
The bench builds the block with a four-entry table and five-bit register tags. At that depth, a handful of accesses is enough to wrap the allocation pointer and evict the oldest entry. The small tag space makes random redefinition strobes regularly hit both base registers and data tags. A random phase draws bases from three registers, offsets from three values and two sizes. This makes exact matches, size mismatches, byte overlaps, different-base flushes and silent stores frequent under random back-pressure on both streams.

// File: rtl/symaddr_pkg.sv
package symaddr_pkg;

  typedef enum logic [2:0] {
    ACT_LD_ISSUE = 3'd0,
    ACT_LD_COPY  = 3'd1,
    ACT_LD_FWD   = 3'd2,
    ACT_ST_ISSUE = 3'd3,
    ACT_ST_DROP  = 3'd4,
    ACT_IO_PASS  = 3'd5
  } act_e;

endpackage

// File: rtl/symaddr_cam.sv
module symaddr_cam #(
  parameter int N_ENTRY = 8,
  parameter int PREG_W  = 7,
  parameter int OFF_W   = 64
) (
  input  logic [N_ENTRY-1:0]             e_valid,
  input  logic [N_ENTRY-1:0][PREG_W-1:0] e_base,
  input  logic [N_ENTRY-1:0][OFF_W-1:0]  e_off,
  input  logic [N_ENTRY-1:0][1:0]        e_size,
  input  logic [PREG_W-1:0]              q_base,
  input  logic [OFF_W-1:0]               q_off,
  input  logic [1:0]                     q_size,
  output logic [N_ENTRY-1:0]             addr_hit,
  output logic [N_ENTRY-1:0]             overlap,
  output logic [N_ENTRY-1:0]             other_base
);

  logic [OFF_W-1:0] q_end;
  assign q_end = q_off + (OFF_W'(1) << q_size);

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
    logic             same_base;
    logic [OFF_W-1:0] e_end;
    assign same_base     = e_base[g] == q_base;
    assign e_end         = e_off[g] + (OFF_W'(1) << e_size[g]);
    assign addr_hit[g]   = e_valid[g] && same_base && (e_off[g] == q_off);
    assign overlap[g]    = e_valid[g] && same_base && (e_off[g] < q_end) && (q_off < e_end);
    assign other_base[g] = e_valid[g] && !same_base;
  end

endmodule

// File: rtl/symaddr_rr.sv
module symaddr_rr #(
  parameter int N_ENTRY = 8,
  localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (adv)
      ptr <= (ptr == IDX_W'(N_ENTRY - 1)) ? '0 : ptr + 1'b1;
  end

  // R11: every allocation moves the victim pointer
  p_rr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (N_ENTRY > 1 && adv) |=> ptr != $past(ptr));

  // R11: pointer only moves on an allocation
  p_rr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));

endmodule

// File: rtl/symaddr_entries.sv
module symaddr_entries #(
  parameter int N_ENTRY = 8,
  parameter int PREG_W  = 7,
  parameter int OFF_W   = 64,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_ENTRY-1:0]             inv_mask,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [PREG_W-1:0]              wr_base,
  input  logic [OFF_W-1:0]               wr_off,
  input  logic [1:0]                     wr_size,
  input  logic [PREG_W-1:0]              wr_tag,
  input  logic                           wr_known,
  input  logic [DATA_W-1:0]              wr_value,
  input  logic                           wr_from_st,
  input  logic                           redef_valid,
  input  logic [PREG_W-1:0]              redef_tag,
  output logic [N_ENTRY-1:0]             e_valid,
  output logic [N_ENTRY-1:0][PREG_W-1:0] e_base,
  output logic [N_ENTRY-1:0][OFF_W-1:0]  e_off,
  output logic [N_ENTRY-1:0][1:0]        e_size,
  output logic [N_ENTRY-1:0][PREG_W-1:0] e_tag,
  output logic [N_ENTRY-1:0]             e_known,
  output logic [N_ENTRY-1:0][DATA_W-1:0] e_value,
  output logic [N_ENTRY-1:0]             e_from_st
);

  logic [N_ENTRY-1:0]             n_valid;
  logic [N_ENTRY-1:0][PREG_W-1:0] n_base;
  logic [N_ENTRY-1:0][OFF_W-1:0]  n_off;
  logic [N_ENTRY-1:0][1:0]        n_size;
  logic [N_ENTRY-1:0][PREG_W-1:0] n_tag;
  logic [N_ENTRY-1:0]             n_known;
  logic [N_ENTRY-1:0][DATA_W-1:0] n_value;
  logic [N_ENTRY-1:0]             n_from_st;

  always_comb begin
    n_valid   = e_valid & ~inv_mask;
    n_base    = e_base;
    n_off     = e_off;
    n_size    = e_size;
    n_tag     = e_tag;
    n_known   = e_known;
    n_value   = e_value;
    n_from_st = e_from_st;
    if (wr_en) begin
      n_valid[wr_idx]   = 1'b1;
      n_base[wr_idx]    = wr_base;
      n_off[wr_idx]     = wr_off;
      n_size[wr_idx]    = wr_size;
      n_tag[wr_idx]     = wr_tag;
      n_known[wr_idx]   = wr_known;
      n_value[wr_idx]   = wr_value;
      n_from_st[wr_idx] = wr_from_st;
    end
    if (redef_valid) begin
      for (int i = 0; i < N_ENTRY; i++)
        if (n_base[i] == redef_tag || n_tag[i] == redef_tag)
          n_valid[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      e_valid <= '0;
    else
      e_valid <= n_valid;
  end

  always_ff @(posedge clk) begin
    e_base    <= n_base;
    e_off     <= n_off;
    e_size    <= n_size;
    e_tag     <= n_tag;
    e_known   <= n_known;
    e_value   <= n_value;
    e_from_st <= n_from_st;
  end

  // checker state: last redefinition seen
  logic              seen_redef;
  logic [PREG_W-1:0] seen_tag;
  logic              stale_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_redef <= 1'b0;
      seen_tag   <= '0;
    end else begin
      seen_redef <= redef_valid;
      seen_tag   <= redef_tag;
    end
  end

  always_comb begin
    stale_left = 1'b0;
    for (int i = 0; i < N_ENTRY; i++)
      if (e_valid[i] && (e_base[i] == seen_tag || e_tag[i] == seen_tag))
        stale_left = 1'b1;
  end

  // R8: nothing keyed on a redefined register survives the strobe
  p_redef_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seen_redef |-> !stale_left);

  // R2: a write that is not cancelled by a redefinition leaves its slot valid
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !redef_valid) |=> e_valid[$past(wr_idx)]);

endmodule

// File: rtl/symaddr_mem_filter.sv
module symaddr_mem_filter
  import symaddr_pkg::*;
#(
  parameter int N_ENTRY = 8,
  parameter int PREG_W  = 7,
  parameter int OFF_W   = 64,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_store,
  input  logic              in_is_io,
  input  logic [PREG_W-1:0] in_base,
  input  logic [OFF_W-1:0]  in_off,
  input  logic [1:0]        in_size,
  input  logic [PREG_W-1:0] in_tag,
  input  logic              in_known,
  input  logic [DATA_W-1:0] in_value,
  input  logic              redef_valid,
  input  logic [PREG_W-1:0] redef_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_act,
  output logic              out_fb_valid,
  output logic [PREG_W-1:0] out_fb_dst,
  output logic [PREG_W-1:0] out_fb_src,
  output logic              out_fb_known,
  output logic [DATA_W-1:0] out_fb_value
);

  localparam int IDX_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;

  logic [N_ENTRY-1:0]             e_valid;
  logic [N_ENTRY-1:0][PREG_W-1:0] e_base;
  logic [N_ENTRY-1:0][OFF_W-1:0]  e_off;
  logic [N_ENTRY-1:0][1:0]        e_size;
  logic [N_ENTRY-1:0][PREG_W-1:0] e_tag;
  logic [N_ENTRY-1:0]             e_known;
  logic [N_ENTRY-1:0][DATA_W-1:0] e_value;
  logic [N_ENTRY-1:0]             e_from_st;

  logic [N_ENTRY-1:0] addr_hit;
  logic [N_ENTRY-1:0] overlap;
  logic [N_ENTRY-1:0] other_base;

  logic [IDX_W-1:0]   rr_ptr;
  logic               rr_adv;
  logic [IDX_W-1:0]   hit_idx;
  logic               any_addr;
  logic               exact;
  logic               silent;
  logic               accept;

  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [N_ENTRY-1:0] inv_mask;
  act_e               act_c;
  logic               fb_c;
  logic [PREG_W-1:0]  fb_dst_c;
  logic [PREG_W-1:0]  fb_src_c;
  logic               fb_kn_c;
  logic [DATA_W-1:0]  fb_val_c;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  symaddr_cam #(.N_ENTRY(N_ENTRY), .PREG_W(PREG_W), .OFF_W(OFF_W)) i_cam (
    .e_valid    (e_valid),
    .e_base     (e_base),
    .e_off      (e_off),
    .e_size     (e_size),
    .q_base     (in_base),
    .q_off      (in_off),
    .q_size     (in_size),
    .addr_hit   (addr_hit),
    .overlap    (overlap),
    .other_base (other_base)
  );

  symaddr_rr #(.N_ENTRY(N_ENTRY)) i_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (rr_adv),
    .ptr   (rr_ptr)
  );

  symaddr_entries #(
    .N_ENTRY(N_ENTRY), .PREG_W(PREG_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) i_entries (
    .clk         (clk),
    .rst_n       (rst_n),
    .inv_mask    (inv_mask),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_base     (in_base),
    .wr_off      (in_off),
    .wr_size     (in_size),
    .wr_tag      (in_tag),
    .wr_known    (in_is_store && in_known),
    .wr_value    (in_is_store ? in_value : '0),
    .wr_from_st  (in_is_store),
    .redef_valid (redef_valid),
    .redef_tag   (redef_tag),
    .e_valid     (e_valid),
    .e_base      (e_base),
    .e_off       (e_off),
    .e_size      (e_size),
    .e_tag       (e_tag),
    .e_known     (e_known),
    .e_value     (e_value),
    .e_from_st   (e_from_st)
  );

  // lowest matching slot; at most one can match
  always_comb begin
    hit_idx = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--)
      if (addr_hit[i]) hit_idx = IDX_W'(i);
  end

  assign any_addr = |addr_hit;
  assign exact    = any_addr && (e_size[hit_idx] == in_size);
  assign silent   = exact &&
                    ((e_known[hit_idx] && in_known && e_value[hit_idx] == in_value) ||
                     (e_tag[hit_idx] == in_tag));

  always_comb begin
    act_c    = ACT_IO_PASS;
    wr_en    = 1'b0;
    wr_idx   = rr_ptr;
    inv_mask = '0;
    rr_adv   = 1'b0;
    fb_c     = 1'b0;
    fb_dst_c = '0;
    fb_src_c = '0;
    fb_kn_c  = 1'b0;
    fb_val_c = '0;
    if (in_is_io) begin
      act_c = ACT_IO_PASS;
    end else if (!in_is_store) begin
      if (exact) begin
        act_c    = e_from_st[hit_idx] ? ACT_LD_FWD : ACT_LD_COPY;
        fb_c     = 1'b1;
        fb_dst_c = in_tag;
        fb_src_c = e_tag[hit_idx];
        fb_kn_c  = e_known[hit_idx];
        fb_val_c = e_value[hit_idx];
      end else begin
        act_c = ACT_LD_ISSUE;
        wr_en = 1'b1;
        if (any_addr) wr_idx = hit_idx;
        else          rr_adv = 1'b1;
      end
    end else if (silent) begin
      act_c = ACT_ST_DROP;
    end else begin
      act_c = ACT_ST_ISSUE;
      wr_en = 1'b1;
      if (|other_base) begin
        inv_mask = '1;
        rr_adv   = 1'b1;
      end else begin
        inv_mask = overlap;
        if (exact) wr_idx = hit_idx;
        else       rr_adv = 1'b1;
      end
    end
    if (!accept) begin
      wr_en    = 1'b0;
      inv_mask = '0;
      rr_adv   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_act      <= '0;
      out_fb_valid <= 1'b0;
      out_fb_dst   <= '0;
      out_fb_src   <= '0;
      out_fb_known <= 1'b0;
      out_fb_value <= '0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_act      <= act_c;
      out_fb_valid <= fb_c;
      out_fb_dst   <= fb_dst_c;
      out_fb_src   <= fb_src_c;
      out_fb_known <= fb_kn_c;
      out_fb_value <= fb_val_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R3: the table never holds two entries for one symbolic address
  p_hit_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0(addr_hit));

  // R1: a stalled result holds
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_act) &&
                                   $stable(out_fb_src) && $stable(out_fb_value)));

  // R6: an I/O access leaves every entry as it was
  p_io_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_is_io && !redef_valid) |=> ($stable(e_valid) && $stable(rr_ptr)));

  // R5: a dropped store leaves the table alone
  p_drop_nochange_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && act_c == ACT_ST_DROP && !redef_valid) |=> $stable(e_valid));

  // R10: feedback travels only with copy or forward actions
  p_fb_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fb_valid) |-> (out_act == 3'd1 || out_act == 3'd2));

endmodule

// File: tb/test_symaddr_mem_filter.sv
module test_symaddr_mem_filter;

  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int PW    = 5;
  localparam int OW    = 64;
  localparam int DW    = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_is_store = 1'b0;
  logic          in_is_io = 1'b0;
  logic [PW-1:0] in_base = '0;
  logic [OW-1:0] in_off = '0;
  logic [1:0]    in_size = '0;
  logic [PW-1:0] in_tag = '0;
  logic          in_known = 1'b0;
  logic [DW-1:0] in_value = '0;
  logic          redef_valid = 1'b0;
  logic [PW-1:0] redef_tag = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [2:0]    out_act;
  logic          out_fb_valid;
  logic [PW-1:0] out_fb_dst;
  logic [PW-1:0] out_fb_src;
  logic          out_fb_known;
  logic [DW-1:0] out_fb_value;

  int checks = 0;
  int errors = 0;
  bit run_cmp = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  symaddr_mem_filter #(.N_ENTRY(N), .PREG_W(PW), .OFF_W(OW), .DATA_W(DW)) i_symaddr_mem_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_store(in_is_store), .in_is_io(in_is_io), .in_base(in_base), .in_off(in_off),
    .in_size(in_size), .in_tag(in_tag), .in_known(in_known), .in_value(in_value),
    .redef_valid(redef_valid), .redef_tag(redef_tag), .out_valid(out_valid),
    .out_ready(out_ready), .out_act(out_act), .out_fb_valid(out_fb_valid),
    .out_fb_dst(out_fb_dst), .out_fb_src(out_fb_src), .out_fb_known(out_fb_known),
    .out_fb_value(out_fb_value)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit              mv [N];
  int              mbase [N];
  longint unsigned moff [N];
  int              msz [N];
  int              mtag [N];
  bit              mkn [N];
  longint unsigned mval [N];
  bit              mfs [N];
  int              mrr;
  bit              ev;
  int              eact;
  bit              efb;
  int              edst;
  int              esrc;
  bit              ekn;
  longint unsigned evl;

  function automatic string req_of(input int a);
    case (a)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R7";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic fill(input int k, input bit kn, input longint unsigned v, input bit fs);
    mv[k]    = 1;
    mbase[k] = int'(in_base);
    moff[k]  = in_off;
    msz[k]   = int'(in_size);
    mtag[k]  = int'(in_tag);
    mkn[k]   = kn;
    mval[k]  = v;
    mfs[k]   = fs;
  endtask

  task automatic model_step();
    int  j;
    int  k;
    bit  hit;
    bit  other;
    longint unsigned qend;
    longint unsigned eend;
    j = 0;
    hit = 0;
    for (int i = 0; i < N; i++)
      if (!hit && mv[i] && mbase[i] == int'(in_base) && moff[i] == in_off) begin
        hit = 1;
        j = i;
      end
    ev = 1; efb = 0; edst = 0; esrc = 0; ekn = 0; evl = 0;
    if (in_is_io) begin
      eact = 5;
    end else if (!in_is_store) begin
      if (hit && msz[j] == int'(in_size)) begin
        eact = mfs[j] ? 2 : 1;
        efb = 1; edst = int'(in_tag); esrc = mtag[j]; ekn = mkn[j]; evl = mval[j];
      end else begin
        eact = 0;
        if (hit) k = j;
        else begin k = mrr; mrr = (mrr + 1) % N; end
        fill(k, 0, 0, 0);
      end
    end else if (hit && msz[j] == int'(in_size) &&
                 ((mkn[j] && in_known && mval[j] == in_value) || mtag[j] == int'(in_tag))) begin
      eact = 4;
    end else begin
      eact = 3;
      other = 0;
      for (int i = 0; i < N; i++) if (mv[i] && mbase[i] != int'(in_base)) other = 1;
      if (other) begin
        for (int i = 0; i < N; i++) mv[i] = 0;
        k = mrr; mrr = (mrr + 1) % N;
      end else begin
        qend = in_off + (64'd1 << in_size);
        for (int i = 0; i < N; i++) begin
          eend = moff[i] + (64'd1 << msz[i]);
          if (mv[i] && mbase[i] == int'(in_base) && moff[i] < qend && in_off < eend) mv[i] = 0;
        end
        if (hit && msz[j] == int'(in_size)) k = j;
        else begin k = mrr; mrr = (mrr + 1) % N; end
      end
      fill(k, in_known, in_value, 1);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
      mrr = 0; ev = 0; eact = 0; efb = 0; edst = 0; esrc = 0; ekn = 0; evl = 0;
    end else begin
      if (in_valid && (!ev || out_ready)) model_step();
      else if (out_ready) ev = 0;
      if (redef_valid)
        for (int i = 0; i < N; i++)
          if (mv[i] && (mbase[i] == int'(redef_tag) || mtag[i] == int'(redef_tag))) mv[i] = 0;
    end
  end

  // cycle-by-cycle comparison, away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n && run_cmp) begin
      chk(out_valid == ev, "R1", "out_valid", out_valid, ev);
      chk(in_ready == (!ev || out_ready), "R1", "in_ready", in_ready, !ev || out_ready);
      if (ev && out_valid) begin
        chk(int'(out_act) == eact, req_of(eact), "action", out_act, eact);
        chk(out_fb_valid == efb, "R10", "fb_valid", out_fb_valid, efb);
        chk(int'(out_fb_dst) == edst, "R10", "fb_dst", out_fb_dst, edst);
        chk(int'(out_fb_src) == esrc, "R10", "fb_src", out_fb_src, esrc);
        chk(out_fb_known == ekn, "R10", "fb_known", out_fb_known, ekn);
        chk(out_fb_value == evl, "R10", "fb_value", out_fb_value, evl);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic do_op(input bit st, input bit io, input int b, input longint unsigned o,
                       input int sz, input int tg, input bit kn, input longint unsigned v,
                       input int xact, input int xsrc, input string req);
    @(negedge clk);
    in_valid = 1; in_is_store = st; in_is_io = io; in_base = PW'(b); in_off = o;
    in_size = 2'(sz); in_tag = PW'(tg); in_known = kn; in_value = v;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk(int'(out_act) == xact, req, "directed action", out_act, xact);
    if (xsrc >= 0) chk(int'(out_fb_src) == xsrc, req, "directed source", out_fb_src, xsrc);
  endtask

  task automatic do_redef(input int t);
    @(negedge clk);
    redef_valid = 1; redef_tag = PW'(t);
    @(negedge clk);
    redef_valid = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: empty after reset
    chk(out_valid == 0, "R12", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R12", "in_ready after reset", in_ready, 1);
    run_cmp = 1;

    do_op(0, 0, 1, 0, 3, 10, 0, 0, 0, -1, "R2");   // slot0
    do_op(0, 0, 1, 0, 3, 11, 0, 0, 1, 10, "R3");
    do_op(1, 0, 1, 8, 3, 12, 1, 55, 3, -1, "R7");  // slot1
    do_op(0, 0, 1, 8, 3, 13, 0, 0, 2, 12, "R4");
    chk(out_fb_known == 1 && out_fb_value == 55, "R4", "forwarded value", out_fb_value, 55);
    do_op(1, 0, 1, 8, 3, 20, 1, 55, 4, -1, "R5");  // equal known value
    do_op(1, 0, 1, 8, 3, 12, 0, 0, 4, -1, "R5");   // same data register
    do_op(0, 0, 1, 0, 2, 14, 0, 0, 0, -1, "R9");   // size mismatch, in place
    do_op(0, 0, 1, 0, 2, 15, 0, 0, 1, 14, "R9");
    do_op(0, 0, 1, 0, 3, 16, 0, 0, 0, -1, "R9");
    do_op(0, 1, 1, 8, 3, 17, 0, 0, 5, -1, "R6");
    do_op(1, 1, 1, 8, 3, 30, 1, 99, 5, -1, "R6");
    do_op(0, 0, 1, 8, 3, 17, 0, 0, 2, 12, "R6");   // table untouched by I/O
    do_redef(1);
    do_op(0, 0, 1, 8, 3, 18, 0, 0, 0, -1, "R8");   // slot2, ptr 3
    do_op(1, 0, 2, 0, 3, 21, 0, 0, 3, -1, "R7");   // flush, slot3, ptr 0
    do_op(0, 0, 1, 8, 3, 22, 0, 0, 0, -1, "R7");   // flushed; slot0, ptr 1
    do_op(0, 0, 3, 0, 3, 23, 0, 0, 0, -1, "R11");  // slot1
    do_op(0, 0, 3, 8, 3, 24, 0, 0, 0, -1, "R11");  // slot2
    do_op(0, 0, 3, 16, 3, 25, 0, 0, 0, -1, "R11"); // slot3 evicts store
    do_op(0, 0, 3, 24, 3, 26, 0, 0, 0, -1, "R11"); // slot0
    do_op(0, 0, 2, 0, 3, 27, 0, 0, 0, -1, "R11");  // evicted; slot1
    do_op(0, 0, 3, 8, 3, 28, 0, 0, 1, 24, "R11");
    do_op(0, 0, 3, 0, 3, 29, 0, 0, 0, -1, "R11");  // evicted
    do_redef(25);                                   // data tag of base3 off16
    do_op(0, 0, 3, 16, 3, 9, 0, 0, 0, -1, "R8");

    // random phase with back-pressure on both sides
    acc = 0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (!(in_valid && !acc)) begin
        in_valid    = ($urandom_range(0, 3) != 0);
        in_is_store = $urandom_range(0, 1);
        in_is_io    = ($urandom_range(0, 15) == 0);
        in_base     = PW'($urandom_range(1, 3));
        in_off      = 64'($urandom_range(0, 2) * 4);
        in_size     = 2'($urandom_range(2, 3));
        in_tag      = PW'($urandom_range(1, 31));
        in_known    = $urandom_range(0, 1);
        in_value    = 64'($urandom_range(1, 2));
      end
      out_ready   = ($urandom_range(0, 2) != 0);
      redef_valid = ($urandom_range(0, 19) == 0);
      redef_tag   = PW'($urandom_range(1, 5));
      #1;
      acc = in_valid && in_ready;
    end
    @(negedge clk);
    in_valid = 0;
    redef_valid = 0;
    out_ready = 1;
    repeat (3) @(negedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule